// File: doc/BRIEF.md
# Raw Receive Word Assembler with Sync Gate

This block sits behind a bit demodulator and turns its stream of recovered bits into 16-bit words for a host. In the default raw setting it starts collecting as soon as the modem enable is set. It does no alignment of any kind, so word boundaries fall wherever the first accepted bit happened to land. Each finished word is placed in a holding register and flagged as valid until the host takes it.

An optional gate cuts down the noise handed to the host before a call begins. With the gate switched on, the block first hunts for a programmable 16-bit pattern, such as 16'h5555 or 16'hAAAA, in the incoming bits. It reports a sync-acquired status when it finds the pattern, and only then starts packing words, beginning with the bit that follows the match. Deciding whether the words are meaningful is left to the host.

The input side is a one-directional stream: `bit_valid` marks a new bit and there is no ready, because a demodulator cannot be stalled. The output side is a valid/ready pair. `word_valid` stays high and `word_data` holds still until the host asserts `word_ready`, and the transfer completes in the cycle both are high. Back-pressure cannot stall the input, though. If the host has not taken a word by the time the next one completes, the newer word replaces the older and a sticky overrun flag records the loss.

Top module: `raw_word_assembler`

## Requirements
- R1: After reset, `word_valid`, `sync_acq` and `overrun` are 0 and `word_data` is 16'h0000.
- R2: With the gate off and `modem_en` high, each `bit_valid` strobe adds one bit. The first bit of a word lands in `word_data[15]` and the sixteenth in `word_data[0]`. `word_valid` is high in the cycle after the clock edge that sampled the sixteenth bit, and is not high before then.
- R3: A bit presented while `bit_valid` is low, or while `modem_en` is low, is not collected and shifts no later word.
- R4: While `word_valid` is high and no new word completes, `word_data` holds its value. A cycle with `word_valid` and `word_ready` both high clears `word_valid` on the next edge.
- R5: If a word completes while `word_valid` is high and `word_ready` is low, the new word replaces the held one, `word_valid` stays high and `overrun` becomes 1. `overrun` then stays 1 until `modem_en` is cleared.
- R6: If a word completes in the same cycle that the host takes the held word, the new word becomes valid and `overrun` is not set.
- R7: With `gate_en` high, no word is delivered until the pattern on `sync_pattern` has been matched by the 16 most recent accepted bits, with the oldest of them at bit 15. `sync_acq` goes high in the cycle after the edge that sampled the final pattern bit.
- R8: After a match, packing starts with the first bit following the matching bit, so the next 16 bits form the first delivered word.
- R9: A match needs at least 16 accepted bits since the hunt started. Bits left over from before enable never count, so pattern 16'h0000 matches only on the sixteenth zero.
- R10: A cycle with `modem_en` low discards any partial word, clears `sync_acq` and `overrun`, and restarts the hunt. The held word and `word_valid` are kept.
- R11: `sync_acq` stays 0 while `gate_en` is low, even when the data contains the pattern.
- R12: Once the gate is acquired it stays acquired while enabled and the hunt stops. A later copy of the pattern in the data is delivered as an ordinary word and does not move the word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modem_en | input | 1 | Reception enable; low stops and clears reception |
| gate_en | input | 1 | Enables the sync-pattern gate |
| sync_pattern | input | 16 | Pattern the gate hunts for, oldest bit at bit 15 |
| bit_valid | input | 1 | Strobe marking a new demodulated bit |
| bit_data | input | 1 | Demodulated bit value |
| word_data | output | 16 | Held receive word, first bit at bit 15 |
| word_valid | output | 1 | A word is waiting for the host |
| word_ready | input | 1 | Host takes the held word when `word_valid` is high |
| sync_acq | output | 1 | Gate pattern has been found |
| overrun | output | 1 | Sticky flag: a word was replaced before it was taken |

## Verification
Off-by-one errors around the word boundary and the match are the main targets. A packer that counted to 15 or 17 would put the wrong bits in the word. A gate that started packing on the matching bit instead of the one after would deliver a word shifted by one. The bench also aims at the read and completion landing in the same cycle, where a careless design would raise a false overrun or drop the new word. It checks that a disable really discards a partial word, which would otherwise show up as a misaligned next word. It checks that the hunt cannot match on stale register contents, which with an all-zero pattern would acquire too early.

// File: rtl/rxw_pkg.sv
`timescale 1ns/1ps
package rxw_pkg;
  typedef enum logic {
    HS_SEARCH = 1'b0,
    HS_LOCKED = 1'b1
  } hunt_state_t;
endpackage

// File: rtl/rxw_sync_hunt.sv
`timescale 1ns/1ps
// Hunts for the gate pattern in the accepted bit stream; locks once found.
module rxw_sync_hunt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         bit_valid,
  input  logic         bit_data,
  input  logic [W-1:0] pattern,
  output logic         locked
);
  import rxw_pkg::*;

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FILL_MAX = CW'(W);
  localparam logic [CW-1:0] FILL_LAST = CW'(W - 1);

  hunt_state_t state;
  logic [W-1:0] window;
  logic [CW-1:0] fill;
  logic [W-1:0] window_nx;
  logic step;
  logic hit;

  assign window_nx = {window[W-2:0], bit_data};
  assign step = enable && bit_valid && (state == HS_SEARCH);
  assign hit = step && (fill >= FILL_LAST) && (window_nx == pattern);
  assign locked = (state == HS_LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state  <= HS_SEARCH;
      window <= '0;
      fill   <= '0;
    end else if (step) begin
      window <= window_nx;
      if (fill != FILL_MAX) fill <= fill + 1'b1;
      if (hit) state <= HS_LOCKED;
    end
  end

  // R9
  lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(enable && bit_valid));

  // R12
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && enable |=> locked);
endmodule

// File: rtl/rxw_packer.sv
`timescale 1ns/1ps
// Shifts accepted bits into a word, first bit ending at the MSB.
module rxw_packer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic         bit_valid,
  input  logic         bit_data,
  output logic         word_done,
  output logic [W-1:0] word_out
);
  localparam int NW = $clog2(W);
  localparam logic [NW-1:0] LAST = NW'(W - 1);

  logic [W-2:0] acc;
  logic [NW-1:0] count;
  logic take;

  assign take = run && bit_valid;
  assign word_out = {acc, bit_data};
  assign word_done = take && (count == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc   <= '0;
      count <= '0;
    end else if (take) begin
      acc   <= word_out[W-2:0];
      count <= word_done ? '0 : count + 1'b1;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid && !clear |=> $stable(count) && $stable(acc));
endmodule

// File: rtl/rxw_word_hold.sv
`timescale 1ns/1ps
// Holding register with valid/ready output and sticky overrun.
module rxw_word_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_ovr,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         rd_ready,
  output logic [W-1:0] data,
  output logic         valid,
  output logic         overrun
);
  logic drain;
  logic lost;

  assign drain = valid && rd_ready;
  assign lost = load && valid && !rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data    <= '0;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (load) begin
        data  <= load_word;
        valid <= 1'b1;
      end else if (drain) begin
        valid <= 1'b0;
      end
      if (clear_ovr) overrun <= 1'b0;
      else if (lost) overrun <= 1'b1;
    end
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !load |=> $stable(data));

  // R4
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && rd_ready && !load |=> !valid);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clear_ovr |=> overrun);

  // R6
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && valid && rd_ready && !overrun && !clear_ovr |=> valid && !overrun);
endmodule

// File: rtl/raw_word_assembler.sv
`timescale 1ns/1ps
// Raw receive word assembler with optional sync-pattern gate.
module raw_word_assembler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         modem_en,
  input  logic         gate_en,
  input  logic [W-1:0] sync_pattern,
  input  logic         bit_valid,
  input  logic         bit_data,
  output logic [W-1:0] word_data,
  output logic         word_valid,
  input  logic         word_ready,
  output logic         sync_acq,
  output logic         overrun
);
  logic hunt_en;
  logic pack_run;
  logic done;
  logic [W-1:0] packed_word;

  assign hunt_en = modem_en && gate_en;
  assign pack_run = modem_en && (!gate_en || sync_acq);

  rxw_sync_hunt #(.W(W)) u_hunt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (hunt_en),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .pattern   (sync_pattern),
    .locked    (sync_acq)
  );

  rxw_packer #(.W(W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!modem_en),
    .run       (pack_run),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .word_done (done),
    .word_out  (packed_word)
  );

  rxw_word_hold #(.W(W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_ovr (!modem_en),
    .load      (done),
    .load_word (packed_word),
    .rd_ready  (word_ready),
    .data      (word_data),
    .valid     (word_valid),
    .overrun   (overrun)
  );

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modem_en |=> !sync_acq && !overrun);

  // R11
  no_lock_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_acq) |-> $past(gate_en));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(!gate_en || sync_acq));

  // R2
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(bit_valid && modem_en));
endmodule

// File: tb/sim_raw_word_assembler.sv
`timescale 1ns/1ps
module sim_raw_word_assembler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modem_en = 1'b0;
  logic gate_en = 1'b0;
  logic [15:0] sync_pattern = 16'h0000;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic word_ready = 1'b0;
  logic [15:0] word_data;
  logic word_valid;
  logic sync_acq;
  logic overrun;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  raw_word_assembler u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .modem_en     (modem_en),
    .gate_en      (gate_en),
    .sync_pattern (sync_pattern),
    .bit_valid    (bit_valid),
    .bit_data     (bit_data),
    .word_data    (word_data),
    .word_valid   (word_valid),
    .word_ready   (word_ready),
    .sync_acq     (sync_acq),
    .overrun      (overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic rd);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data = b;
    word_ready = rd;
    @(negedge clk);
    bit_valid = 1'b0;
    word_ready = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) send_bit(w[i], 1'b0);
  endtask

  task automatic send_word_rd(input logic [15:0] w, input logic rd_last);
    for (int i = 15; i > 0; i--) send_bit(w[i], 1'b0);
    send_bit(w[0], rd_last);
  endtask

  task automatic host_read();
    @(negedge clk);
    word_ready = 1'b1;
    @(negedge clk);
    word_ready = 1'b0;
  endtask

  task automatic set_en(input logic m);
    @(negedge clk);
    modem_en = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 word_valid", word_valid, 0);
    chk("R1 sync_acq", sync_acq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 word_data", word_data, 0);
  endtask

  task automatic t_raw();
    gate_en = 1'b0;
    sync_pattern = 16'hA5C3;
    set_en(1'b1);
    send_bits(16'hA5C3, 15);
    chk("R2 not valid after 15 bits", word_valid, 0);
    send_bit(1'b1, 1'b0);
    chk("R2 valid after 16th bit", word_valid, 1);
    chk("R2 word order", word_data, 16'hA5C3);
    chk("R11 no acq with gate off", sync_acq, 0);
    repeat (3) @(negedge clk);
    chk("R4 data held", word_data, 16'hA5C3);
    chk("R4 valid held", word_valid, 1);
    host_read();
    chk("R4 valid cleared by read", word_valid, 0);
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bit_data = i[0];
    end
    send_word_rd(16'h1234, 1'b0);
    chk("R3 strobe-less bits ignored", word_data, 16'h1234);
    host_read();
    set_en(1'b0);
    send_bits(16'hFFFF, 5);
    chk("R3 no word while disabled", word_valid, 0);
    set_en(1'b1);
    send_word_rd(16'hBEEF, 1'b0);
    chk("R3 disabled bits ignored", word_data, 16'hBEEF);
    host_read();
  endtask

  task automatic t_overrun();
    send_word_rd(16'h1111, 1'b0);
    chk("R5 no overrun on first", overrun, 0);
    send_word_rd(16'h2222, 1'b0);
    chk("R5 newer word kept", word_data, 16'h2222);
    chk("R5 valid stays", word_valid, 1);
    chk("R5 overrun set", overrun, 1);
    host_read();
    send_word_rd(16'h3333, 1'b0);
    host_read();
    chk("R5 overrun sticky", overrun, 1);
    set_en(1'b0);
    chk("R10 overrun cleared by disable", overrun, 0);
    set_en(1'b1);
  endtask

  task automatic t_same_cycle();
    send_word_rd(16'h4444, 1'b0);
    send_word_rd(16'h5555, 1'b1);
    chk("R6 new word valid", word_valid, 1);
    chk("R6 new word data", word_data, 16'h5555);
    chk("R6 no overrun", overrun, 0);
    host_read();
    chk("R6 drained", word_valid, 0);
  endtask

  task automatic t_partial();
    send_word_rd(16'h0F0F, 1'b0);
    set_en(1'b0);
    chk("R10 held word kept", word_data, 16'h0F0F);
    chk("R10 valid kept", word_valid, 1);
    set_en(1'b1);
    host_read();
    send_bits(16'hFE00, 7);
    set_en(1'b0);
    set_en(1'b1);
    send_word_rd(16'h6789, 1'b0);
    chk("R10 partial discarded", word_data, 16'h6789);
    host_read();
  endtask

  task automatic t_gate();
    set_en(1'b0);
    gate_en = 1'b1;
    sync_pattern = 16'hF0E1;
    set_en(1'b1);
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bits(16'hF0E1, 15);
    chk("R7 no acq before last bit", sync_acq, 0);
    send_bit(1'b1, 1'b0);
    chk("R7 acq after pattern", sync_acq, 1);
    chk("R7 nothing delivered", word_valid, 0);
    send_word_rd(16'h3C5A, 1'b0);
    chk("R8 first word after match", word_data, 16'h3C5A);
    chk("R8 valid", word_valid, 1);
    host_read();
    send_word_rd(16'hF0E1, 1'b0);
    chk("R12 pattern as data", word_data, 16'hF0E1);
    chk("R12 acq sticky", sync_acq, 1);
    host_read();
    send_word_rd(16'h0246, 1'b0);
    chk("R12 alignment kept", word_data, 16'h0246);
    host_read();
    set_en(1'b0);
    chk("R10 acq cleared", sync_acq, 0);
  endtask

  task automatic t_fill();
    sync_pattern = 16'h0000;
    set_en(1'b1);
    send_bits(16'h0000, 15);
    chk("R9 no early match", sync_acq, 0);
    send_bit(1'b0, 1'b0);
    chk("R9 match on 16th zero", sync_acq, 1);
    set_en(1'b0);
    gate_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_ignore();
    t_overrun();
    t_same_cycle();
    t_partial();
    t_gate();
    t_fill();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule